// File: doc/BRIEF.md
# Host Keyboard Controller Command Engine

This block is the host-side front end of a keyboard and pointing-device controller. The host sees two byte-wide ports, selected by one address bit: a data port (offset 0x60) and a command/status port (offset 0x64). Bytes written to the command port are decoded at once. Most commands act directly on three internal registers: a mode register, a status register and an output-port register. Others push a reply byte into a response queue. A small group of commands only arms a pending write, and the next byte on the data port is then routed to the destination that command names.

The block drives an A20 gate line and a one-cycle system reset request from the output-port register. It drives a scan-code translation enable from the mode register. It also raises the keyboard and auxiliary interrupt lines from two "device has data" inputs, gated by the mode bits. Replies leave through a byte strobe tagged keyboard or auxiliary. Data bytes meant for the attached devices leave through a separate strobe per device. The serial device protocol and the devices themselves sit outside.

Top module: `kbc_cmd_engine`

## Requirements
- R1: Out of reset, mode reads 0x03, status reads 0x18, the output port reads 0xCF, A20 is 1, translation enable is 0, and no strobe, interrupt or reset request is active.
- R2: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a pending write. Other commands leave an armed write untouched. The next data-port byte is steered by it: to mode, to the output port, to the keyboard reply queue, to the auxiliary reply queue, or to the mouse. The pending write is then cleared, so a later data byte goes to the keyboard.
- R3: A data-port byte with nothing armed appears on the keyboard forward strobe. After 0xD4 it appears on the mouse forward strobe instead. At most one of the reply strobe and the two forward strobes is active in any cycle.
- R4: Command 0x20 queues the mode byte, 0xD0 queues the output-port view and 0xC0 queues 0x80. All of them use the keyboard tag (q_aux_o = 0). Every reply and forward strobe lasts one cycle and follows the accepting edge.
- R5: Command 0xAA sets status bit 2 and queues 0x55. Commands 0xAB and 0xA9 each queue 0x00.
- R6: Command 0xAD sets mode bit 4 and 0xAE clears it. Command 0xA7 sets mode bit 5 and 0xA8 clears it. Mode never changes except after an accepted write.
- R7: Command 0xDF sets output-port bit 1 and raises A20. Command 0xDD clears bit 1 and lowers A20. A20 always equals output-port bit 1.
- R8: Any command 0xF0 to 0xFF with bit 0 = 0 gives a reset request pulse of exactly one cycle. With bit 0 = 1 it has no effect.
- R9: A data byte written to the output port after 0xD1 sets A20 from its bit 1. It raises a reset pulse when its bit 0 is 0.
- R10: A data byte written to the mode register after 0x60 sets translation enable from its bit 6. The interrupts follow every mode change in the next cycle.
- R11: The keyboard interrupt is keyboard-ready AND mode bit 0 AND NOT mode bit 4. The aux interrupt is aux-ready AND NOT keyboard-ready AND mode bit 1. Status bit 0 and output-port bit 4 show either-ready. Status bit 5 and output-port bit 5 show aux-only-ready, so keyboard data wins.
- R12: A command-port write sets status bit 3 and a data-port write clears it.
- R13: A command outside the decoded set produces no reply and no pulse. It changes no register other than status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_i | input | 1 | Host write strobe |
| host_sel_cmd_i | input | 1 | 1 = command port, 0 = data port |
| host_byte_i | input | 8 | Host write byte |
| kbd_ready_i | input | 1 | Keyboard device has data waiting |
| aux_ready_i | input | 1 | Auxiliary device has data waiting |
| status_o | output | 8 | Status byte seen on a status-port read |
| mode_o | output | 8 | Mode register |
| port_o | output | 8 | Output-port view (bits 4/5 from ready flags) |
| q_valid_o | output | 1 | Reply byte strobe |
| q_byte_o | output | 8 | Reply byte |
| q_aux_o | output | 1 | Reply tag: 1 = auxiliary channel |
| kbd_tx_valid_o | output | 1 | Byte forwarded to keyboard |
| aux_tx_valid_o | output | 1 | Byte forwarded to mouse |
| dev_byte_o | output | 8 | Forwarded byte |
| a20_o | output | 1 | A20 gate |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| xlat_en_o | output | 1 | Scan-code translation enable |
| irq_kbd_o | output | 1 | Keyboard interrupt |
| irq_aux_o | output | 1 | Auxiliary interrupt |

## Verification
The bench builds the block with its default values: mode reset 0x03, output-port reset 0xCF, input-port reply 0x80 and self-test reply 0x55. Each of the 256 command codes is swept from a fresh reset, followed by two data bytes. This covers every decode, every armed route, and the clearing of the pending write, for both the known and the unknown codes. A second sweep crosses 32 mode values with all four ready-flag combinations to cover the interrupt gating and the status and output-port flags. Directed sequences cover the reset pulse from an output-port write, interrupt changes after the keyboard enable and disable commands, and the rule that non-arming commands keep a pending write armed.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // mode register bit positions
  localparam int MB_KIRQ = 0;
  localparam int MB_AIRQ = 1;
  localparam int MB_KDIS = 4;
  localparam int MB_ADIS = 5;
  localparam int MB_XLAT = 6;
  // output-port bit positions
  localparam int PB_RSTN = 0;
  localparam int PB_A20  = 1;
  localparam int PB_KOBF = 4;
  localparam int PB_AOBF = 5;
  // status bit positions
  localparam int SB_OBF  = 0;
  localparam int SB_TEST = 2;
  localparam int SB_CMD  = 3;
  localparam int SB_UNLK = 4;
  localparam int SB_AOBF = 5;

  typedef enum logic [2:0] {
    PEND_NONE, PEND_MODE, PEND_PORT, PEND_KQ, PEND_AQ, PEND_AUXDEV
  } pend_e;

  typedef enum logic [1:0] {QSRC_MODE, QSRC_PORT, QSRC_CONST} qsrc_e;

  typedef struct packed {
    logic  arm;
    pend_e arm_kind;
    logic  q_en;
    qsrc_e q_src;
    byte_t q_const;
    logic  kdis_set;
    logic  kdis_clr;
    logic  adis_set;
    logic  adis_clr;
    logic  a20_on;
    logic  a20_off;
    logic  sys_rst;
    logic  selftest;
  } cmd_act_t;

  function automatic logic aux_only_f(input logic k, input logic a);
    return a & ~k;
  endfunction

  function automatic logic irq_kbd_f(input logic k, input byte_t m);
    return k & m[MB_KIRQ] & ~m[MB_KDIS];
  endfunction

  function automatic logic irq_aux_f(input logic k, input logic a, input byte_t m);
    return aux_only_f(k, a) & m[MB_AIRQ];
  endfunction

  function automatic byte_t port_view_f(input byte_t p, input logic k, input logic a);
    byte_t v;
    v = p;
    v[PB_KOBF] = k | a;
    v[PB_AOBF] = aux_only_f(k, a);
    return v;
  endfunction

  function automatic byte_t status_f(input logic k, input logic a,
                                     input logic st, input logic cf);
    byte_t v;
    v = '0;
    v[SB_OBF]  = k | a;
    v[SB_TEST] = st;
    v[SB_CMD]  = cf;
    v[SB_UNLK] = 1'b1;
    v[SB_AOBF] = aux_only_f(k, a);
    return v;
  endfunction
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
#(
  parameter byte_t INPORT_VAL   = 8'h80,
  parameter byte_t SELFTEST_VAL = 8'h55
) (
  input  byte_t    cmd_i,
  output cmd_act_t act_o
);
  localparam logic [3:0] PULSE_NIB = 4'hF;

  always_comb begin
    act_o          = '0;
    act_o.arm_kind = PEND_NONE;
    act_o.q_src    = QSRC_CONST;
    if (cmd_i[BYTE_W-1 -: 4] == PULSE_NIB) begin
      // pulse group: bit 0 low means reset, else nothing
      act_o.sys_rst = ~cmd_i[0];
    end else begin
      unique case (cmd_i)
        8'h20: begin act_o.q_en = 1'b1; act_o.q_src = QSRC_MODE; end
        8'hD0: begin act_o.q_en = 1'b1; act_o.q_src = QSRC_PORT; end
        8'hC0: begin act_o.q_en = 1'b1; act_o.q_const = INPORT_VAL; end
        8'hAA: begin act_o.q_en = 1'b1; act_o.q_const = SELFTEST_VAL; act_o.selftest = 1'b1; end
        8'hAB, 8'hA9: act_o.q_en = 1'b1;
        8'h60: begin act_o.arm = 1'b1; act_o.arm_kind = PEND_MODE;   end
        8'hD1: begin act_o.arm = 1'b1; act_o.arm_kind = PEND_PORT;   end
        8'hD2: begin act_o.arm = 1'b1; act_o.arm_kind = PEND_KQ;     end
        8'hD3: begin act_o.arm = 1'b1; act_o.arm_kind = PEND_AQ;     end
        8'hD4: begin act_o.arm = 1'b1; act_o.arm_kind = PEND_AUXDEV; end
        8'hAD: act_o.kdis_set = 1'b1;
        8'hAE: act_o.kdis_clr = 1'b1;
        8'hA7: act_o.adis_set = 1'b1;
        8'hA8: act_o.adis_clr = 1'b1;
        8'hDF: act_o.a20_on   = 1'b1;
        8'hDD: act_o.a20_off  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/kbc_state_regs.sv
module kbc_state_regs
  import kbc_pkg::*;
#(
  parameter byte_t MODE_INIT = 8'h03,
  parameter byte_t PORT_INIT = 8'hCF
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_fire_i,
  input  logic     data_fire_i,
  input  cmd_act_t act_i,
  input  logic     mode_wr_i,
  input  logic     port_wr_i,
  input  byte_t    wdata_i,
  output byte_t    mode_q_o,
  output byte_t    port_q_o,
  output logic     selftest_q_o,
  output logic     cmdflag_q_o,
  output logic     a20_o,
  output logic     xlat_o,
  output logic     sys_rst_o
);
  byte_t mode_d, port_d;
  logic  rst_evt;

  always_comb begin
    mode_d = mode_q_o;
    port_d = port_q_o;
    if (cmd_fire_i) begin
      if (act_i.kdis_set) mode_d[MB_KDIS] = 1'b1;
      if (act_i.kdis_clr) mode_d[MB_KDIS] = 1'b0;
      if (act_i.adis_set) mode_d[MB_ADIS] = 1'b1;
      if (act_i.adis_clr) mode_d[MB_ADIS] = 1'b0;
      if (act_i.a20_on)   port_d[PB_A20]  = 1'b1;
      if (act_i.a20_off)  port_d[PB_A20]  = 1'b0;
    end
    if (mode_wr_i) mode_d = wdata_i;
    if (port_wr_i) port_d = wdata_i;
  end

  // reset request: pulse command, or output port written with bit 0 low
  assign rst_evt = (cmd_fire_i & act_i.sys_rst) | (port_wr_i & ~wdata_i[PB_RSTN]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q_o     <= MODE_INIT;
      port_q_o     <= PORT_INIT;
      selftest_q_o <= 1'b0;
      cmdflag_q_o  <= 1'b1;
      sys_rst_o    <= 1'b0;
    end else begin
      mode_q_o  <= mode_d;
      port_q_o  <= port_d;
      sys_rst_o <= rst_evt;
      if (cmd_fire_i & act_i.selftest) selftest_q_o <= 1'b1;
      if (cmd_fire_i)       cmdflag_q_o <= 1'b1;
      else if (data_fire_i) cmdflag_q_o <= 1'b0;
    end
  end

  assign a20_o  = port_q_o[PB_A20];
  assign xlat_o = mode_q_o[MB_XLAT];

  assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> !sys_rst_o);
  assert_mode_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q_o) |-> $past(cmd_fire_i | data_fire_i));
  assert_a20_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(a20_o) |-> $past(cmd_fire_i | data_fire_i));
endmodule

// File: rtl/kbc_irq_eval.sv
module kbc_irq_eval
  import kbc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  kbd_ready_i,
  input  logic  aux_ready_i,
  input  byte_t mode_i,
  input  byte_t port_q_i,
  input  logic  selftest_i,
  input  logic  cmdflag_i,
  output logic  irq_kbd_o,
  output logic  irq_aux_o,
  output byte_t status_o,
  output byte_t port_view_o
);
  assign irq_kbd_o   = irq_kbd_f(kbd_ready_i, mode_i);
  assign irq_aux_o   = irq_aux_f(kbd_ready_i, aux_ready_i, mode_i);
  assign status_o    = status_f(kbd_ready_i, aux_ready_i, selftest_i, cmdflag_i);
  assign port_view_o = port_view_f(port_q_i, kbd_ready_i, aux_ready_i);

  assert_kbd_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_kbd_o |-> (!mode_i[MB_KDIS] && kbd_ready_i && !irq_aux_o));
  assert_aux_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_aux_o |-> (status_o[SB_AOBF] && port_view_o[PB_AOBF]));
endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
  import kbc_pkg::*;
#(
  parameter byte_t MODE_INIT    = 8'h03,
  parameter byte_t PORT_INIT    = 8'hCF,
  parameter byte_t INPORT_VAL   = 8'h80,
  parameter byte_t SELFTEST_VAL = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_i,
  input  logic              host_sel_cmd_i,
  input  logic [BYTE_W-1:0] host_byte_i,
  input  logic              kbd_ready_i,
  input  logic              aux_ready_i,
  output logic [BYTE_W-1:0] status_o,
  output logic [BYTE_W-1:0] mode_o,
  output logic [BYTE_W-1:0] port_o,
  output logic              q_valid_o,
  output logic [BYTE_W-1:0] q_byte_o,
  output logic              q_aux_o,
  output logic              kbd_tx_valid_o,
  output logic              aux_tx_valid_o,
  output logic [BYTE_W-1:0] dev_byte_o,
  output logic              a20_o,
  output logic              sys_rst_req_o,
  output logic              xlat_en_o,
  output logic              irq_kbd_o,
  output logic              irq_aux_o
);
  logic     cmd_fire, data_fire;
  cmd_act_t act;
  pend_e    pend_q;
  byte_t    mode_q, port_q, port_view, status_w;
  logic     selftest_q, cmdflag_q;
  logic     mode_wr, port_wr;
  logic     q_cmd_evt, q_data_evt;
  byte_t    q_cmd_byte;

  assign cmd_fire  = host_wr_i & host_sel_cmd_i;
  assign data_fire = host_wr_i & ~host_sel_cmd_i;

  kbc_cmd_decode #(.INPORT_VAL(INPORT_VAL), .SELFTEST_VAL(SELFTEST_VAL)) u_dec (
    .cmd_i (host_byte_i),
    .act_o (act)
  );

  // one-shot pending write latch
  always_ff @(posedge clk) begin
    if (!rst_n)                  pend_q <= PEND_NONE;
    else if (cmd_fire & act.arm) pend_q <= act.arm_kind;
    else if (data_fire)          pend_q <= PEND_NONE;
  end

  assign mode_wr = data_fire & (pend_q == PEND_MODE);
  assign port_wr = data_fire & (pend_q == PEND_PORT);

  kbc_state_regs #(.MODE_INIT(MODE_INIT), .PORT_INIT(PORT_INIT)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_fire_i   (cmd_fire),
    .data_fire_i  (data_fire),
    .act_i        (act),
    .mode_wr_i    (mode_wr),
    .port_wr_i    (port_wr),
    .wdata_i      (host_byte_i),
    .mode_q_o     (mode_q),
    .port_q_o     (port_q),
    .selftest_q_o (selftest_q),
    .cmdflag_q_o  (cmdflag_q),
    .a20_o        (a20_o),
    .xlat_o       (xlat_en_o),
    .sys_rst_o    (sys_rst_req_o)
  );

  kbc_irq_eval u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .kbd_ready_i (kbd_ready_i),
    .aux_ready_i (aux_ready_i),
    .mode_i      (mode_q),
    .port_q_i    (port_q),
    .selftest_i  (selftest_q),
    .cmdflag_i   (cmdflag_q),
    .irq_kbd_o   (irq_kbd_o),
    .irq_aux_o   (irq_aux_o),
    .status_o    (status_w),
    .port_view_o (port_view)
  );

  // reply byte selection
  always_comb begin
    unique case (act.q_src)
      QSRC_MODE: q_cmd_byte = mode_q;
      QSRC_PORT: q_cmd_byte = port_view;
      default:   q_cmd_byte = act.q_const;
    endcase
  end

  assign q_cmd_evt  = cmd_fire & act.q_en;
  assign q_data_evt = data_fire & ((pend_q == PEND_KQ) | (pend_q == PEND_AQ));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid_o      <= 1'b0;
      q_byte_o       <= '0;
      q_aux_o        <= 1'b0;
      kbd_tx_valid_o <= 1'b0;
      aux_tx_valid_o <= 1'b0;
      dev_byte_o     <= '0;
    end else begin
      q_valid_o      <= q_cmd_evt | q_data_evt;
      q_aux_o        <= q_data_evt & (pend_q == PEND_AQ);
      kbd_tx_valid_o <= data_fire & (pend_q == PEND_NONE);
      aux_tx_valid_o <= data_fire & (pend_q == PEND_AUXDEV);
      if (q_cmd_evt)       q_byte_o <= q_cmd_byte;
      else if (q_data_evt) q_byte_o <= host_byte_i;
      if (data_fire)       dev_byte_o <= host_byte_i;
    end
  end

  assign status_o = status_w;
  assign mode_o   = mode_q;
  assign port_o   = port_view;

  assert_latch_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_fire |=> (pend_q == PEND_NONE));
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({q_valid_o, kbd_tx_valid_o, aux_tx_valid_o}));
  assert_strobe_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid_o | kbd_tx_valid_o | aux_tx_valid_o) |-> $past(host_wr_i));
  assert_cmdflag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> status_o[SB_CMD]);
endmodule

// File: tb/kbc_cmd_engine_tb_top.sv
module kbc_cmd_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, sel = 1'b0;
  logic [7:0] wbyte = '0;
  logic kr = 1'b0, ar = 1'b0;
  logic [7:0] status, mode, port, qbyte, dbyte;
  logic qv, qa, ktx, atx, a20, srst, xlat, ik, ia;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  kbc_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr_i(wr), .host_sel_cmd_i(sel),
    .host_byte_i(wbyte), .kbd_ready_i(kr), .aux_ready_i(ar),
    .status_o(status), .mode_o(mode), .port_o(port), .q_valid_o(qv),
    .q_byte_o(qbyte), .q_aux_o(qa), .kbd_tx_valid_o(ktx), .aux_tx_valid_o(atx),
    .dev_byte_o(dbyte), .a20_o(a20), .sys_rst_req_o(srst), .xlat_en_o(xlat),
    .irq_kbd_o(ik), .irq_aux_o(ia)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one write; returns at the negedge after the accepting posedge
  task automatic put(input logic is_cmd, input logic [7:0] b);
    wr = 1'b1; sel = is_cmd; wbyte = b;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [7:0] eq, em, ep;
    logic eqv, ea20;
    string rq;
    do_reset();
    // R1 reset state
    chk("R1", "status", status, 8'h18);
    chk("R1", "mode", mode, 8'h03);
    chk("R1", "port", port, 8'hCF);
    chk("R1", "a20", a20, 1);
    chk("R1", "xlat", xlat, 0);
    chk("R1", "strobes", {qv, ktx, atx, srst, ik, ia}, 0);

    // sweep every command code from a fresh reset
    for (int c = 0; c < 256; c++) begin
      do_reset();
      put(1'b1, 8'(c));
      eqv = 0; eq = 8'h00; em = 8'h03; ep = 8'hCF; ea20 = 1; rq = "R13";
      case (c)
        'h20: begin eqv = 1; eq = 8'h03; rq = "R4"; end
        'hD0: begin eqv = 1; eq = 8'hCF; rq = "R4"; end
        'hC0: begin eqv = 1; eq = 8'h80; rq = "R4"; end
        'hAA: begin eqv = 1; eq = 8'h55; rq = "R5"; end
        'hAB, 'hA9: begin eqv = 1; rq = "R5"; end
        'hAD: begin em = 8'h13; rq = "R6"; end
        'hA7: begin em = 8'h23; rq = "R6"; end
        'hAE, 'hA8: rq = "R6";
        'hDD: begin ep = 8'hCD; ea20 = 0; rq = "R7"; end
        'hDF: rq = "R7";
        'h60, 'hD1, 'hD2, 'hD3, 'hD4: rq = "R2";
        default: if (c >= 'hF0) rq = "R8";
      endcase
      chk(rq, $sformatf("qv cmd %h", c), qv, eqv);
      if (eqv) chk(rq, $sformatf("qbyte cmd %h", c), qbyte, eq);
      chk(rq, $sformatf("qaux cmd %h", c), qa, 0);
      chk(rq, $sformatf("fwd cmd %h", c), {ktx, atx}, 0);
      chk(rq, $sformatf("mode cmd %h", c), mode, em);
      chk(rq, $sformatf("port cmd %h", c), port, ep);
      chk(rq, $sformatf("a20 cmd %h", c), a20, ea20);
      chk("R8", $sformatf("rst cmd %h", c), srst, (c >= 'hF0) && !c[0]);
      chk("R12", $sformatf("status cmd %h", c), status, (c == 'hAA) ? 8'h1C : 8'h18);
      @(negedge clk);
      chk("R8", $sformatf("rst gone cmd %h", c), srst, 0);
      // first data byte, routed by any armed write
      put(1'b0, 8'hE5);
      chk("R12", $sformatf("status data %h", c), status, (c == 'hAA) ? 8'h14 : 8'h10);
      chk("R2", $sformatf("q after %h", c), {qv, qa},
          (c == 'hD2) ? 2'b10 : (c == 'hD3) ? 2'b11 : 2'b00);
      if (c == 'hD2 || c == 'hD3) chk("R2", "qbyte data", qbyte, 8'hE5);
      chk("R3", $sformatf("fwd after %h", c), {ktx, atx},
          (c == 'hD4) ? 2'b01 : (c inside {'h60, 'hD1, 'hD2, 'hD3}) ? 2'b00 : 2'b10);
      if (ktx | atx) chk("R3", "dev byte", dbyte, 8'hE5);
      if (c == 'h60) begin
        chk("R10", "mode written", mode, 8'hE5);
        chk("R10", "xlat", xlat, 1);
      end
      if (c == 'hD1) begin
        chk("R9", "port written", port, 8'hC5);
        chk("R9", "a20 from bit1", a20, 0);
        chk("R9", "no rst bit0=1", srst, 0);
      end
      // second data byte: latch must be clear
      put(1'b0, 8'h3C);
      chk("R2", $sformatf("cleared after %h", c), {ktx, atx, qv}, 3'b100);
      chk("R3", "dev byte 2", dbyte, 8'h3C);
    end

    // R9 output-port write with bit 0 low
    do_reset();
    put(1'b1, 8'hD1); put(1'b0, 8'hCC);
    chk("R9", "rst pulse", srst, 1);
    chk("R9", "a20 low", a20, 0);
    @(negedge clk);
    chk("R9", "rst one cycle", srst, 0);

    // R2 non-arming command keeps armed write
    do_reset();
    put(1'b1, 8'h60); put(1'b1, 8'h20);
    chk("R4", "mode reply", qbyte, 8'h03);
    put(1'b0, 8'h41);
    chk("R2", "mode after interleave", mode, 8'h41);
    chk("R10", "xlat after interleave", xlat, 1);

    // R10 interrupts follow enable/disable commands
    do_reset();
    kr = 1'b1; #1;
    chk("R10", "irq kbd on", ik, 1);
    @(negedge clk);
    put(1'b1, 8'hAD);
    chk("R10", "irq kbd off after disable", ik, 0);
    put(1'b1, 8'hAE);
    chk("R10", "irq kbd on after enable", ik, 1);
    kr = 1'b0; ar = 1'b1;
    @(negedge clk);
    put(1'b1, 8'hD0);
    chk("R4", "port reply aux-only", qbyte, 8'hFF);
    ar = 1'b0;

    // R11 sweep over mode values and ready flags
    for (int m = 0; m < 32; m++) begin
      do_reset();
      put(1'b1, 8'h60); put(1'b0, 8'(m));
      for (int p = 0; p < 4; p++) begin
        logic k, a, ao;
        k = p[0]; a = p[1]; ao = a & !k;
        kr = k; ar = a; #1;
        chk("R11", $sformatf("irqk m%0d p%0d", m, p), ik, k & m[0] & !m[4]);
        chk("R11", $sformatf("irqa m%0d p%0d", m, p), ia, ao & m[1]);
        chk("R11", $sformatf("status m%0d p%0d", m, p), status,
            8'h10 | {2'b00, ao, 4'b0000, (k | a)});
        chk("R11", $sformatf("port m%0d p%0d", m, p), port,
            8'hCF | {2'b00, ao, (k | a), 4'b0000});
      end
      kr = 1'b0; ar = 1'b0;
      @(negedge clk);
    end

    done = 1;
    summary();
  end
endmodule